// File: doc/BRIEF.md
# Extended-Precision Exponent/Significand Splitter

This block takes one 80-bit extended-precision operand, which is the value at the top of a register stack, and separates it into two extended-precision results. The first is the significand, rescaled so that its true exponent is zero. The second is the operand's unbiased exponent, written as an extended-precision real number. The operand format is a sign in bit 79, a 15-bit exponent with bias 16383 in bits 78:64, and a 64-bit significand with an explicit integer bit in bit 63.

The surrounding stack logic raises `start` with the operand. It also supplies the zero-divide mask and two stack-state inputs: `stk_empty` means the source slot holds nothing, and `stk_full` means no free slot is left for the push. When `sig_vld` and `exp_vld` are both high at `done`, the caller decrements its top pointer, writes `sig_out` into the new top slot, and writes `exp_out` into the slot just below it. Special operands follow fixed rules: zeros, denormals, infinities, quiet and signaling NaNs, and unsupported encodings. The block also reports stack faults through a flag and a condition bit. The invalid-operation response is always the masked one.

Top module: `fp_xsplit`

## Requirements
- R1: A `start` seen high while the block is idle is accepted at that clock edge. `done` is high for exactly one cycle, after the third rising edge counted from the accepting edge. A `start` seen while an operation is in progress is ignored.
- R2: For a normal operand (exponent 1..32766 with bit 63 set), `sig_out` keeps the operand's sign and all 64 significand bits and carries biased exponent 0x3FFF. `exp_out` is the real value of (exponent − 16383).
- R3: The exponent real is encoded as follows. A true exponent of zero gives all-zero bits (+0.0). Any other value E gives sign = (E<0), a significand equal to |E| shifted left until bit 63 is 1, and biased exponent 16383 + floor(log2|E|).
- R4: A denormal operand (exponent field 0, nonzero significand) raises `flag_den`. Its significand is shifted left by its leading-zero count n so that bit 63 becomes 1, and its true exponent is −16382 − n.
- R5: A zero operand with `zd_mask`=1 raises `flag_zdiv`. The results are valid: `sig_out` is zero with the operand's sign, and `exp_out` is negative infinity (0xFFFF_8000000000000000).
- R6: A zero operand with `zd_mask`=0 raises `flag_zdiv` and leaves `sig_vld` and `exp_vld` low, so no push happens.
- R7: An infinite operand (exponent 0x7FFF, significand 0x8000000000000000) gives `sig_out` equal to the operand and `exp_out` equal to +infinity (0x7FFF_8000000000000000).
- R8: A quiet NaN (exponent 0x7FFF, bits 63 and 62 set) is copied unchanged to both results. A signaling NaN (bit 63 set, bit 62 clear, bits 61:0 nonzero) raises `flag_inv`, and both results are the operand with bit 62 set.
- R9: An unsupported encoding (nonzero exponent field with bit 63 clear) raises `flag_inv`. Both results are the default NaN 0xFFFF_C000000000000000.
- R10: A stack fault raises `flag_stk` and `flag_inv` and leaves both valid outputs low. With `stk_empty`=1, `cc1`=0, and this takes priority over `stk_full`. With only `stk_full`=1, `cc1`=1.
- R11: After reset, `done`, both valid outputs, all flags and `cc1` are 0. Each `done` replaces every flag with those of the latest operation only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation on `operand` |
| operand | input | 80 | Extended-precision source value |
| zd_mask | input | 1 | 1 = zero-divide exception masked |
| stk_empty | input | 1 | Source stack slot empty (underflow) |
| stk_full | input | 1 | No free slot for the push (overflow) |
| done | output | 1 | One-cycle completion pulse |
| sig_out | output | 80 | Significand result (new top of stack) |
| exp_out | output | 80 | Exponent result (slot below top) |
| sig_vld | output | 1 | `sig_out` is to be written |
| exp_vld | output | 1 | `exp_out` is to be written |
| flag_inv | output | 1 | Invalid operation |
| flag_den | output | 1 | Denormal operand |
| flag_zdiv | output | 1 | Zero divide |
| flag_stk | output | 1 | Stack fault |
| cc1 | output | 1 | Condition bit C1 (0 underflow, 1 overflow) |

## Verification
Every result, every flag and `done` is due together, after the third rising edge counted from the edge that accepts `start`. The first edge registers the operand, the second classifies and normalizes it, and the third converts the exponent and loads the outputs. The bench drives on falling edges and samples on the falling edges after the first and second rising edges, where `done` must still be low. It then samples on the falling edge after the third rising edge, where `done` must be high and every output is compared. A start held through the busy cycles, followed by three more idle samples, shows that no second `done` appears.

// File: rtl/fp_xsplit.sv
`timescale 1ns/1ps
module fp_xsplit #(
  parameter int EW = 15,
  parameter int MW = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [EW+MW:0]   operand,
  input  logic             zd_mask,
  input  logic             stk_empty,
  input  logic             stk_full,
  output logic             done,
  output logic [EW+MW:0]   sig_out,
  output logic [EW+MW:0]   exp_out,
  output logic             sig_vld,
  output logic             exp_vld,
  output logic             flag_inv,
  output logic             flag_den,
  output logic             flag_zdiv,
  output logic             flag_stk,
  output logic             cc1
);
  localparam int FW   = EW + MW + 1;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int IW   = EW + 2;
  localparam int LZW  = $clog2(MW) + 1;
  localparam logic [FW-1:0] NAN_DEF = {1'b1, {EW{1'b1}}, 2'b11, {(MW-2){1'b0}}};
  localparam logic [FW-1:0] POS_INF = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};
  localparam logic [FW-1:0] NEG_INF = {1'b1, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_NORM, S_CONV} st_t;
  typedef enum logic [2:0] {K_NUM, K_ZERO, K_INF, K_QNAN, K_SNAN, K_BAD, K_UNDER, K_OVER} kind_t;

  function automatic logic [LZW-1:0] lzc(input logic [MW-1:0] v);
    int n;
    n = MW;
    for (int i = 0; i < MW; i++)
      if (v[i]) n = MW - 1 - i;
    return LZW'(n);
  endfunction

  st_t st;
  logic [FW-1:0] op_q;
  logic zm_q, un_q, ov_q;

  kind_t kind_q;
  logic sgn_q, den_q;
  logic [MW-1:0] man_q, raw_q;
  logic signed [IW-1:0] ex_q;

  // classification and normalization stage
  wire           s_in = op_q[FW-1];
  wire [EW-1:0]  e_in = op_q[FW-2:MW];
  wire [MW-1:0]  m_in = op_q[MW-1:0];
  wire [LZW-1:0] lz1  = lzc(m_in);
  wire           e_lo = (e_in == '0);
  wire           e_hi = (e_in == '1);

  kind_t kind_n;
  always_comb begin
    if (un_q)                      kind_n = K_UNDER;
    else if (ov_q)                 kind_n = K_OVER;
    else if (e_lo)                 kind_n = (m_in == '0) ? K_ZERO : K_NUM;
    else if (!m_in[MW-1])          kind_n = K_BAD;
    else if (!e_hi)                kind_n = K_NUM;
    else if (m_in[MW-2:0] == '0)   kind_n = K_INF;
    else if (m_in[MW-2])           kind_n = K_QNAN;
    else                           kind_n = K_SNAN;
  end

  wire [MW-1:0] man_n = e_lo ? (m_in << lz1) : m_in;
  wire signed [IW-1:0] ex_n = e_lo ? (IW'(1 - BIAS) - IW'(lz1)) : (IW'(e_in) - IW'(BIAS));

  // exponent-to-real conversion stage
  wire [IW-1:0]  ex_abs = ex_q[IW-1] ? IW'(-ex_q) : IW'(ex_q);
  wire [MW-1:0]  ex_ext = MW'(ex_abs);
  wire [LZW-1:0] lz2    = lzc(ex_ext);
  wire [MW-1:0]  cv_man = ex_ext << lz2;
  wire [EW-1:0]  cv_exp = EW'(BIAS + MW - 1) - EW'(lz2);
  wire [FW-1:0]  ex_real = (ex_q == '0) ? '0 : {ex_q[IW-1], cv_exp, cv_man};
  wire [FW-1:0]  quiet   = {sgn_q, {EW{1'b1}}, raw_q | (MW'(1) << (MW - 2))};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op_q <= '0; zm_q <= 1'b0; un_q <= 1'b0; ov_q <= 1'b0;
      kind_q <= K_NUM; sgn_q <= 1'b0; den_q <= 1'b0;
      man_q <= '0; raw_q <= '0; ex_q <= '0;
      done <= 1'b0; sig_out <= '0; exp_out <= '0;
      sig_vld <= 1'b0; exp_vld <= 1'b0;
      flag_inv <= 1'b0; flag_den <= 1'b0; flag_zdiv <= 1'b0; flag_stk <= 1'b0; cc1 <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          op_q <= operand; zm_q <= zd_mask; un_q <= stk_empty; ov_q <= stk_full;
          st <= S_NORM;
        end
        S_NORM: begin
          kind_q <= kind_n; sgn_q <= s_in; den_q <= e_lo && (m_in != '0);
          man_q <= man_n; raw_q <= m_in; ex_q <= ex_n;
          st <= S_CONV;
        end
        default: begin
          st <= S_IDLE;
          done <= 1'b1;
          flag_inv <= 1'b0; flag_den <= 1'b0; flag_zdiv <= 1'b0; flag_stk <= 1'b0; cc1 <= 1'b0;
          sig_vld <= 1'b1; exp_vld <= 1'b1;
          case (kind_q)
            K_NUM: begin
              sig_out <= {sgn_q, EW'(BIAS), man_q};
              exp_out <= ex_real;
              flag_den <= den_q;
            end
            K_ZERO: begin
              flag_zdiv <= 1'b1;
              sig_vld <= zm_q; exp_vld <= zm_q;
              sig_out <= {sgn_q, {(FW-1){1'b0}}};
              exp_out <= NEG_INF;
            end
            K_INF: begin
              sig_out <= {sgn_q, {EW{1'b1}}, raw_q};
              exp_out <= POS_INF;
            end
            K_QNAN: begin
              sig_out <= {sgn_q, {EW{1'b1}}, raw_q};
              exp_out <= {sgn_q, {EW{1'b1}}, raw_q};
            end
            K_SNAN: begin
              flag_inv <= 1'b1;
              sig_out <= quiet; exp_out <= quiet;
            end
            K_BAD: begin
              flag_inv <= 1'b1;
              sig_out <= NAN_DEF; exp_out <= NAN_DEF;
            end
            default: begin
              flag_inv <= 1'b1; flag_stk <= 1'b1;
              cc1 <= (kind_q == K_OVER);
              sig_vld <= 1'b0; exp_vld <= 1'b0;
            end
          endcase
        end
      endcase
    end
  end

  // R1
  lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st == S_IDLE) |=> ##2 done);

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  stk_novld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flag_stk) |-> (!sig_vld && !exp_vld));

  // R2
  sig_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sig_vld && sig_out[FW-2:MW] != '1 && sig_out[FW-2:0] != '0)
      |-> sig_out[FW-2:MW] == EW'(BIAS));

  // R5
  zero_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flag_zdiv && exp_vld) |-> exp_out == NEG_INF);

  // R3
  exp_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exp_vld && exp_out[FW-2:0] != '0) |-> exp_out[MW-1]);
endmodule

// File: tb/fp_xsplit_bench.sv
`timescale 1ns/1ps
module fp_xsplit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [79:0] operand = '0;
  logic zd_mask = 1'b1, stk_empty = 1'b0, stk_full = 1'b0;
  logic done, sig_vld, exp_vld, flag_inv, flag_den, flag_zdiv, flag_stk, cc1;
  logic [79:0] sig_out, exp_out;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  fp_xsplit u_fp_xsplit (
    .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
    .zd_mask(zd_mask), .stk_empty(stk_empty), .stk_full(stk_full),
    .done(done), .sig_out(sig_out), .exp_out(exp_out),
    .sig_vld(sig_vld), .exp_vld(exp_vld), .flag_inv(flag_inv),
    .flag_den(flag_den), .flag_zdiv(flag_zdiv), .flag_stk(flag_stk), .cc1(cc1)
  );

  // row: {tag[3:0], operand, {zd_mask, stk_empty, stk_full}, sig, exp, {vld, inv, den, zdiv, stk, c1}}
  localparam int NV = 21;
  localparam logic [252:0] VEC [NV] = '{
    {4'd2,  80'h3FFF_8000000000000000, 3'b100, 80'h3FFF_8000000000000000, 80'h0000_0000000000000000, 6'b100000}, // R2
    {4'd2,  80'h4000_C000000000000000, 3'b100, 80'h3FFF_C000000000000000, 80'h3FFF_8000000000000000, 6'b100000}, // R2
    {4'd2,  80'hBFFE_A000000000000000, 3'b100, 80'hBFFF_A000000000000000, 80'hBFFF_8000000000000000, 6'b100000}, // R2
    {4'd3,  80'h400A_8000000000000000, 3'b100, 80'h3FFF_8000000000000000, 80'h4002_B000000000000000, 6'b100000}, // R3
    {4'd3,  80'h0001_8000000000000000, 3'b100, 80'h3FFF_8000000000000000, 80'hC00C_FFF8000000000000, 6'b100000}, // R3
    {4'd3,  80'h7FFE_FFFFFFFFFFFFFFFF, 3'b100, 80'h3FFF_FFFFFFFFFFFFFFFF, 80'h400C_FFFC000000000000, 6'b100000}, // R3
    {4'd4,  80'h0000_0000000000000001, 3'b100, 80'h3FFF_8000000000000000, 80'hC00D_807A000000000000, 6'b101000}, // R4
    {4'd4,  80'h8000_4000000000000003, 3'b100, 80'hBFFF_8000000000000006, 80'hC00C_FFFC000000000000, 6'b101000}, // R4
    {4'd5,  80'h0000_0000000000000000, 3'b100, 80'h0000_0000000000000000, 80'hFFFF_8000000000000000, 6'b100100}, // R5
    {4'd5,  80'h8000_0000000000000000, 3'b100, 80'h8000_0000000000000000, 80'hFFFF_8000000000000000, 6'b100100}, // R5
    {4'd6,  80'h8000_0000000000000000, 3'b000, 80'h0,                     80'h0,                     6'b000100}, // R6
    {4'd7,  80'h7FFF_8000000000000000, 3'b100, 80'h7FFF_8000000000000000, 80'h7FFF_8000000000000000, 6'b100000}, // R7
    {4'd7,  80'hFFFF_8000000000000000, 3'b100, 80'hFFFF_8000000000000000, 80'h7FFF_8000000000000000, 6'b100000}, // R7
    {4'd8,  80'h7FFF_C000000000001234, 3'b100, 80'h7FFF_C000000000001234, 80'h7FFF_C000000000001234, 6'b100000}, // R8
    {4'd8,  80'hFFFF_8000000000000001, 3'b100, 80'hFFFF_C000000000000001, 80'hFFFF_C000000000000001, 6'b110000}, // R8
    {4'd9,  80'h4000_4000000000000000, 3'b100, 80'hFFFF_C000000000000000, 80'hFFFF_C000000000000000, 6'b110000}, // R9
    {4'd9,  80'h7FFF_0000000000000005, 3'b100, 80'hFFFF_C000000000000000, 80'hFFFF_C000000000000000, 6'b110000}, // R9
    {4'd10, 80'h3FFF_8000000000000000, 3'b110, 80'h0,                     80'h0,                     6'b010010}, // R10
    {4'd10, 80'h3FFF_8000000000000000, 3'b101, 80'h0,                     80'h0,                     6'b010011}, // R10
    {4'd10, 80'h0000_0000000000000000, 3'b111, 80'h0,                     80'h0,                     6'b010010}, // R10
    {4'd11, 80'h4000_8000000000000000, 3'b100, 80'h3FFF_8000000000000000, 80'h3FFF_8000000000000000, 6'b100000}  // R11
  };

  task automatic check80(input int tag, input string what, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check1(input int tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // drive at a falling edge; accepting edge follows; done due after third rising edge
  task automatic run_op(input int tag, input logic [79:0] op, input logic [2:0] ctl);
    @(negedge clk);
    operand = op; {zd_mask, stk_empty, stk_full} = ctl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check1(1, "done early after edge 1", done, 1'b0); // R1
    @(negedge clk);
    check1(1, "done early after edge 2", done, 1'b0); // R1
    @(negedge clk);
    check1(tag, "done after edge 3", done, 1'b1);     // R1
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL R1 watchdog expired: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check1(11, "reset done", done, 1'b0);
    check1(11, "reset sig_vld", sig_vld, 1'b0);
    check1(11, "reset exp_vld", exp_vld, 1'b0);
    check1(11, "reset flags", |{flag_inv, flag_den, flag_zdiv, flag_stk, cc1}, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [252:0] v;
      int tag;
      v = VEC[i];
      tag = int'(v[252:249]);
      run_op(tag, v[248:169], v[168:166]);
      check1(tag, "sig_vld", sig_vld, v[5]);
      check1(tag, "exp_vld", exp_vld, v[5]);
      check1(tag, "flag_inv", flag_inv, v[4]);
      check1(tag, "flag_den", flag_den, v[3]);
      check1(tag, "flag_zdiv", flag_zdiv, v[2]);
      check1(tag, "flag_stk", flag_stk, v[1]);
      check1(tag, "cc1", cc1, v[0]);
      if (v[5]) begin
        check80(tag, "sig_out", sig_out, v[165:86]);
        check80(tag, "exp_out", exp_out, v[85:6]);
      end
    end

    // R1: start held while busy with a different operand is ignored
    @(negedge clk);
    operand = 80'h400A_8000000000000000; {zd_mask, stk_empty, stk_full} = 3'b100; start = 1'b1;
    @(negedge clk);
    operand = 80'h0000_0000000000000000; stk_empty = 1'b1;
    check1(1, "busy done early 1", done, 1'b0);
    @(negedge clk);
    check1(1, "busy done early 2", done, 1'b0);
    start = 1'b0; stk_empty = 1'b0;
    @(negedge clk);
    check1(1, "busy done", done, 1'b1);
    check80(1, "busy exp_out", exp_out, 80'h4002_B000000000000000);
    check1(1, "busy flag_stk", flag_stk, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check1(1, "no second done", done, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule